// File: doc/BRIEF.md
# Sixteen-Bit Serial Command Writer

This block pushes one 16-bit command into a single serial peripheral over a three-wire write link: an active-low select, a serial clock and a serial data line. The command is made of an 8-bit register address and an 8-bit value. The address goes out first and the value second, and each byte is shifted out with its most significant bit first. A client presents the two bytes together with a one-cycle start pulse. The block accepts that pulse only while its ready output is high.

The serial clock idles low. Its high and low phases each last `HALF_DIV` system clocks. Data changes only while the clock is low, so the peripheral can take each bit on the rising edge. After the sixteenth falling edge the block waits one more half period and then releases select. The clock does not rise again before select is high. A guard of `GAP_CYC` system clocks follows each frame before ready returns. When `CAPTURE_EN` is set, the return line is sampled on every falling edge. The 16 sampled bits are shown as one word when select rises.

Top module: `spi_word_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `cs_n_o` is 1, `sclk_o` is 0, `mosi_o` is 0, `ready_o` is 1, `rdata_o` is 0 and `rdata_vld_o` is 0.
- R2: A start sampled while `ready_o` is 1 drives `cs_n_o` to 0 on that clock edge. From that edge on, `mosi_o` already carries address bit 7, before the first serial clock rise.
- R3: The word seen on the sixteen rising `sclk_o` edges is `{addr_i, data_i}` as captured at start, with bit 15 first and bit 0 last.
- R4: `sclk_o` is 0 whenever `cs_n_o` is 1. Counting system edges from the accepting edge, the first rise comes after `HALF_DIV` edges. Every later high and low phase in the frame lasts exactly `HALF_DIV` edges.
- R5: `mosi_o` changes only on the edge where `sclk_o` falls, or on the accepting edge. It is stable for the whole high phase.
- R6: Exactly sixteen rises occur per frame. `cs_n_o` returns to 1 exactly `HALF_DIV` edges after the sixteenth fall, with `sclk_o` low.
- R7: `ready_o` is 0 from the accepting edge until `GAP_CYC` edges after `cs_n_o` rises. A start given while `ready_o` is 0 is ignored and changes neither the frame in progress nor the state after it.
- R8: If start is held high, the next frame is accepted on the first edge at which `ready_o` is 1. `cs_n_o` then stays high for exactly `GAP_CYC`+1 edges between frames.
- R9: With capture enabled, `miso_i` is sampled on each edge where `sclk_o` falls, and the first sample lands in bit 15. The 16-bit result appears on `rdata_o` on the edge where `cs_n_o` rises. On that same edge `rdata_vld_o` is 1 for one cycle, and `rdata_o` holds its value until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one frame |
| addr_i | input | ADDR_W | Register address byte, sent first |
| data_i | input | DATA_W | Data byte, sent second |
| ready_o | output | 1 | High when a start will be accepted |
| cs_n_o | output | 1 | Active-low peripheral select |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| miso_i | input | 1 | Serial data from the peripheral |
| rdata_o | output | ADDR_W+DATA_W | Word sampled from `miso_i` in the last frame |
| rdata_vld_o | output | 1 | One-cycle strobe when `rdata_o` updates |

## Verification
Two events can meet in one cycle: a start request and the last cycle of the guard interval, when ready is about to return. The bench raises start in the last cycle of the guard and expects it to be ignored. It also holds start high through the end of a frame and expects the next frame to begin on the very next edge after ready returns. It judges both cases by counting select-high cycles and by checking that the serial data of the frame in progress is left untouched. A second overlap is the last clock fall and the capture of the final return bit. The bench drives a fresh random return pattern in every frame and compares the whole word at the select rise.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } sw_state_e;
endpackage

// File: rtl/spi_word_phase.sv
// Half-period timer: pulses tick_o every HALF_DIV cycles while run_i is high.
module spi_word_phase #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)           cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_word_gap.sv
// Guard-interval timer: done_o rises in the GAP_CYC-th cycle of en_i.
module spi_word_gap #(
  parameter int GAP_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || cnt_q == LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_word_shift.sv
// Transmit shifter with optional receive capture, MSB first both ways.
module spi_word_shift #(
  parameter int W          = 16,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i)       tx_d = word_i;
    else if (shift_i) tx_d = {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign mosi_o = tx_q[W-1];

  generate
    if (CAPTURE_EN) begin : g_cap
      logic [W-1:0] rx_q, rx_d;
      always_comb begin
        rx_d = rx_q;
        if (shift_i) rx_d = {rx_q[W-2:0], miso_i};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
      end
      assign rx_o = rx_q;
    end else begin : g_nocap
      logic unused_miso;
      assign unused_miso = miso_i;
      assign rx_o = '0;
    end
  endgenerate
endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx
  import spi_word_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int HALF_DIV   = 4,
  parameter int GAP_CYC    = 10,
  parameter bit CAPTURE_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic                     ready_o,
  output logic                     cs_n_o,
  output logic                     sclk_o,
  output logic                     mosi_o,
  input  logic                     miso_i,
  output logic [ADDR_W+DATA_W-1:0] rdata_o,
  output logic                     rdata_vld_o
);
  localparam int W  = ADDR_W + DATA_W;
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  sw_state_e     st_q, st_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          sclk_q, sclk_d;
  logic          csn_q, csn_d;
  logic [W-1:0]  rdata_q, rdata_d;
  logic          vld_q, vld_d;
  logic          load, shift, tick, gap_done, run;
  logic [W-1:0]  rx_word;

  assign run = (st_q == ST_LEAD) || (st_q == ST_SHIFT) || (st_q == ST_TRAIL);

  spi_word_phase #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
  );

  spi_word_gap #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .en_i(st_q == ST_GAP), .done_o(gap_done)
  );

  spi_word_shift #(.W(W), .CAPTURE_EN(CAPTURE_EN)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i({addr_i, data_i}),
    .shift_i(shift), .miso_i(miso_i), .mosi_o(mosi_o), .rx_o(rx_word)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    sclk_d  = sclk_q;
    csn_d   = csn_q;
    rdata_d = rdata_q;
    vld_d   = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_LEAD;
        csn_d  = 1'b0;
        bcnt_d = '0;
        load   = 1'b1;
      end
      ST_LEAD: if (tick) begin
        st_d   = ST_SHIFT;
        sclk_d = 1'b1;
      end
      ST_SHIFT: if (tick) begin
        if (sclk_q) begin
          sclk_d = 1'b0;
          shift  = 1'b1;          // falling edge: capture and advance
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == LAST_BIT) st_d = ST_TRAIL;
        end else begin
          sclk_d = 1'b1;
        end
      end
      ST_TRAIL: if (tick) begin
        st_d    = ST_GAP;
        csn_d   = 1'b1;
        rdata_d = rx_word;
        vld_d   = 1'b1;
      end
      ST_GAP: if (gap_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bcnt_q  <= '0;
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      bcnt_q  <= bcnt_d;
      sclk_q  <= sclk_d;
      csn_q   <= csn_d;
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign cs_n_o      = csn_q;
  assign sclk_o      = sclk_q;
  assign rdata_o     = rdata_q;
  assign rdata_vld_o = vld_q;
endmodule

// File: rtl/spi_word_tx_chk.sv
module spi_word_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ready_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic rdata_vld_o
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o); // R4

  AST_ACCEPT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !cs_n_o); // R2

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R5

  AST_MOSI_NO_RISE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(mosi_o)); // R5

  AST_SELECT_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (!sclk_o && !$past(sclk_o))); // R6

  AST_NOT_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !ready_o); // R7

  AST_STROBE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld_o |-> $rose(cs_n_o)); // R9
endmodule

bind spi_word_tx spi_word_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
  .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .rdata_vld_o(rdata_vld_o)
);

// File: tb/sim_spi_word_tx.sv
`timescale 1ns/1ps
module sim_spi_word_tx;
  localparam int BH   = 3;
  localparam int BG   = 6;
  localparam int LAST = 33*BH + BG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        miso_i = 1'b0;
  logic        ready_o, cs_n_o, sclk_o, mosi_o, rdata_vld_o;
  logic [15:0] rdata_o;
  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_word_tx #(.ADDR_W(8), .DATA_W(8), .HALF_DIV(BH), .GAP_CYC(BG),
                .CAPTURE_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .ready_o(ready_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .rdata_o(rdata_o),
    .rdata_vld_o(rdata_vld_o)
  );

  // Expected waveforms, t = system edges since the accepting edge.
  function automatic bit e_sclk(int t);
    return (t >= 0) && (t < 32*BH) && (((t / BH) % 2) == 1);
  endfunction
  function automatic bit e_csn(int t);
    return t >= 33*BH;
  endfunction
  function automatic bit e_ready(int t);
    return t >= LAST;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] d,
                           input logic [15:0] mp, input int ig_t);
    logic [15:0] w;
    w = {a, d};
    while (!ready_o) @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = 1'b0; addr_i = 8'($urandom); data_i = 8'($urandom);
    for (int t = 0; t <= LAST + 2; t++) begin
      if (t > 0) @(negedge clk);
      start_i = 1'b0;
      chk(cs_n_o == e_csn(t), "R2/R6 cs_n", 16'(cs_n_o), 16'(e_csn(t)));
      chk(sclk_o == e_sclk(t), "R4 sclk", 16'(sclk_o), 16'(e_sclk(t)));
      chk(ready_o == e_ready(t), "R7 ready", 16'(ready_o), 16'(e_ready(t)));
      if (t < 32*BH)  // R3 R5: bit k held over its low and high phase
        chk(mosi_o == w[15 - t/(2*BH)], "R3/R5 mosi", 16'(mosi_o),
            16'(w[15 - t/(2*BH)]));
      if (e_sclk(t) && !e_sclk(t-1)) miso_i = mp[15 - t/(2*BH)];
      chk(rdata_vld_o == (t == 33*BH), "R9 vld", 16'(rdata_vld_o),
          16'(t == 33*BH));
      if (t >= 33*BH) chk(rdata_o == mp, "R9 rdata", rdata_o, mp);
      if (t == ig_t) begin  // R7: this start must be ignored
        start_i = 1'b1; addr_i = ~a; data_i = ~d;
      end
    end
  endtask

  initial begin
    int hi;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b0, "R1 lines",
        {13'd0, cs_n_o, sclk_o, mosi_o}, 16'h4);
    chk(ready_o == 1'b1 && rdata_vld_o == 1'b0, "R1 ready", 16'(ready_o), 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata_o == 16'h0 && cs_n_o == 1'b1, "R1 after release", rdata_o, 16'h0);

    // Directed corners
    run_frame(8'h80, 8'h01, 16'hA5C3, -1);       // R3 edge bits only
    run_frame(8'hFF, 8'hFF, 16'h0000, 0);        // R7 start at accept+0
    run_frame(8'h00, 8'h00, 16'hFFFF, LAST - 1); // R7 start in last guard cycle
    run_frame(8'h0B, 8'h03, 16'h8001, 16*BH);    // R7 start mid-frame

    // R8: start held high across the end of a frame
    while (!ready_o) @(negedge clk);
    start_i = 1'b1; addr_i = 8'h0C; data_i = 8'h01;
    @(negedge clk);
    while (!cs_n_o) @(negedge clk);
    hi = 0;
    while (cs_n_o && hi < 200) begin hi++; @(negedge clk); end
    chk(hi == BG + 1, "R8 select-high gap", 16'(hi), 16'(BG + 1));
    start_i = 1'b0;
    @(negedge clk);
    while (!ready_o) @(negedge clk);

    // Random frames with optional ignored starts
    for (int i = 0; i < 40; i++) begin
      int ig;
      ig = ($urandom % 2) ? int'($urandom % LAST) : -1;
      run_frame(8'($urandom), 8'($urandom), 16'($urandom), ig);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule